// File: doc/BRIEF.md
# Converter Conversion Sequencer

This block is the digital sequencer of a sigma-delta converter. It decides when conversions run and when the active-low data-ready output falls. It tracks two reset sources, a level-sensitive pin and a one-cycle opcode strobe. After either one it holds conversions off for a fixed initialization window. Conversions then start from a start pin level or from a latched start opcode. A stop opcode clears the latched start.

All timing is counted in master-clock cycles. The settling delay before the first data-ready comes from the rate code and the power mode. In continuous mode the conversion period is a quarter of that delay. Writing the rate register or the respiration register restarts the filter, and the settling count begins again. In single-shot mode the block delivers one settled result and then stops until a fresh start. A marker output flags the fourth data-ready pulse of a run, which is the first fully settled sample after an input step.

Top module: `conv_seq`

## Requirements
- R1: While `rst_n` is low, `data_ready_n` is 1, `conv_active` is 0, `init_busy` is 1, `settled_mark` is 0 and `rate_err` is 0.
- R2: After `rst_n` rises, or after the last clock edge that samples `rst_pin_n` low or `cmd_reset` high, `init_busy` stays high for exactly 18 clock edges. During that window the block starts no conversion, even with `start_pin` high, and a reset also stops any running conversion.
- R3: Conversions run only while `start_pin` is high or a `cmd_start` strobe has been latched. `cmd_stop` clears the latched start. While the block is halted, `data_ready_n` stays 1.
- R4: `single_shot` = 0 selects continuous conversion and `single_shot` = 1 selects single-shot. The mode is captured when settling begins.
- R5: On the edge that starts conversions, `conv_active` rises while `data_ready_n` stays 1. `data_ready_n` first falls S clock edges after that edge, where S is the settling time.
- R6: When `low_power` = 0, S for `rate_code` 0 through 6 is 296, 584, 1160, 2312, 4616, 9224 and 18440.
- R7: When `low_power` = 1, S for the same codes is 584, 1160, 2312, 4616, 9224, 18440 and 36872.
- R8: A `cfg_wr` strobe while conversions run returns the block to settling with `data_ready_n` high. The next falling edge of data-ready follows S edges after the strobe's edge.
- R9: `settled_mark` is high only during the low phase of the fourth data-ready pulse since settling last began.
- R10: `rate_code` 7 is reserved. It uses the timing of code 6 and sets `rate_err`. `rate_err` stays set until the next reset.
- R11: In single-shot mode, `data_ready_n` stays low for one conversion period P = S/4 after settling. Conversions then stop and `conv_active` falls. No further pulse comes until a new start, which is a rising edge of `start_pin`, a `cmd_start`, or a halt followed by a start.
- R12: In continuous mode, `data_ready_n` falls once every P = S/4 clock cycles and stays low for 4 cycles each time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low chip reset |
| rst_pin_n | input | 1 | Synchronous active-low reset pin level |
| start_pin | input | 1 | Start pin level |
| cmd_reset | input | 1 | One-cycle reset opcode strobe |
| cmd_start | input | 1 | One-cycle start opcode strobe |
| cmd_stop | input | 1 | One-cycle stop opcode strobe |
| cfg_wr | input | 1 | Strobe: rate or respiration register written |
| rate_code | input | 3 | Decimation rate code |
| low_power | input | 1 | 1 = low-power mode, 0 = high-resolution mode |
| single_shot | input | 1 | 1 = single-shot, 0 = continuous |
| conv_active | output | 1 | Settling or converting |
| data_ready_n | output | 1 | Active-low data-ready |
| init_busy | output | 1 | Configuration initialization in progress |
| settled_mark | output | 1 | Marks the fourth data-ready pulse |
| rate_err | output | 1 | Sticky reserved-rate-code flag |

## Verification
The bench measures the exact number of edges to the first data-ready fall for several rates and both power modes. A one-cycle slip in the settle comparison, or a wrong shift in the lookup, shows up there as a count off by one or by a factor of two. It restarts the filter once during settling and once during running. A design that ignored the write would deliver data-ready about a hundred cycles early, and one that kept running would leave data-ready toggling. The bench also checks that a held start pin does not retrigger a single-shot run, and that the marker fires on the fourth pulse and not on a neighbour. A start held high across a reset must still wait out the full 18-cycle initialization. The reserved rate code must take the longest timing and leave a flag that only a reset clears.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_RUN    = 2'd2
  } seq_state_e;
endpackage

// File: rtl/conv_seq_lut.sv
module conv_seq_lut #(
  parameter int CNT_W    = 16,
  parameter int BASE     = 288,
  parameter int OFFS     = 8,
  parameter int MAX_CODE = 6
) (
  input  logic [2:0]       code,
  input  logic             low_power,
  output logic [CNT_W-1:0] settle,
  output logic [CNT_W-1:0] period,
  output logic             reserved
);
  localparam logic [CNT_W-1:0] BASE_V = CNT_W'(BASE);
  localparam logic [CNT_W-1:0] OFFS_V = CNT_W'(OFFS);

  logic [2:0] eff_code;
  logic [3:0] shamt;

  always_comb begin
    reserved = (32'(code) > MAX_CODE);
    eff_code = reserved ? 3'(MAX_CODE) : code;
    shamt    = {1'b0, eff_code} + {3'b000, low_power};
    // doubling per code step plus a fixed pipeline overhead
    settle   = (BASE_V << shamt) + OFFS_V;
    // quarter of the settling time, rounded to nearest
    period   = (settle + CNT_W'(2)) >> 2;
  end
endmodule

// File: rtl/conv_seq_rst.sv
module conv_seq_rst #(
  parameter int INIT_CYC = 18
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rst_pin_n,
  input  logic cmd_reset,
  output logic soft_rst,
  output logic init_busy
);
  localparam int IW = $clog2(INIT_CYC + 1);

  logic [IW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;

  assign soft_rst  = ~rst_pin_n | cmd_reset;
  assign init_busy = busy_q;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (soft_rst) begin
      cnt_d  = '0;
      busy_d = 1'b1;
    end else if (busy_q) begin
      if (cnt_q == IW'(INIT_CYC - 1)) busy_d = 1'b0;
      else                            cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assert_init_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (init_busy && cnt_q == '0));
endmodule

// File: rtl/conv_seq_run.sv
module conv_seq_run (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic start_pin,
  input  logic cmd_start,
  input  logic cmd_stop,
  output logic run_req,
  output logic start_evt
);
  logic latch_q, latch_d;
  logic pin_q;

  always_comb begin
    latch_d = latch_q;
    if (soft_rst)       latch_d = 1'b0;
    else if (cmd_stop)  latch_d = 1'b0;
    else if (cmd_start) latch_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= 1'b0;
      pin_q   <= 1'b0;
    end else begin
      latch_q <= latch_d;
      pin_q   <= start_pin;
    end
  end

  assign run_req   = start_pin | latch_q;
  assign start_evt = cmd_start | (start_pin & ~pin_q);

  assert_stop_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stop && !start_pin) |=> !run_req);
endmodule

// File: rtl/conv_seq.sv
module conv_seq
  import conv_seq_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int INIT_CYC    = 18,
  parameter int PULSE_W     = 4,
  parameter int SETTLE_BASE = 288,
  parameter int SETTLE_OFFS = 8,
  parameter int FLAG_PULSE  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rst_pin_n,
  input  logic       start_pin,
  input  logic       cmd_reset,
  input  logic       cmd_start,
  input  logic       cmd_stop,
  input  logic       cfg_wr,
  input  logic [2:0] rate_code,
  input  logic       low_power,
  input  logic       single_shot,
  output logic       conv_active,
  output logic       data_ready_n,
  output logic       init_busy,
  output logic       settled_mark,
  output logic       rate_err
);
  localparam int NP_W = $clog2(FLAG_PULSE + 2);

  logic             soft_rst, run_req, start_evt;
  logic [CNT_W-1:0] lut_settle, lut_period;
  logic             lut_rsvd;

  conv_seq_rst #(.INIT_CYC(INIT_CYC)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_pin_n(rst_pin_n), .cmd_reset(cmd_reset),
    .soft_rst(soft_rst), .init_busy(init_busy)
  );

  conv_seq_run u_run (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .start_pin(start_pin),
    .cmd_start(cmd_start), .cmd_stop(cmd_stop),
    .run_req(run_req), .start_evt(start_evt)
  );

  conv_seq_lut #(.CNT_W(CNT_W), .BASE(SETTLE_BASE), .OFFS(SETTLE_OFFS)) u_lut (
    .code(rate_code), .low_power(low_power),
    .settle(lut_settle), .period(lut_period), .reserved(lut_rsvd)
  );

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, set_q, set_d, per_q, per_d;
  logic             ssm_q, ssm_d, done_q, done_d, err_q, err_d;
  logic [NP_W-1:0]  np_q, np_d;
  logic             load;

  // begin settling: from idle on a start, or restart on a rate/respiration write
  assign load = run_req & ((state_q == ST_IDLE)
                           ? (~init_busy & (~done_q | start_evt))
                           : cfg_wr);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    set_d   = set_q;
    per_d   = per_q;
    ssm_d   = ssm_q;
    done_d  = done_q;
    np_d    = np_q;
    err_d   = err_q;
    if (soft_rst) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
      done_d  = 1'b0;
      np_d    = '0;
      err_d   = 1'b0;
    end else if (load) begin
      state_d = ST_SETTLE;
      cnt_d   = '0;
      set_d   = lut_settle;
      per_d   = lut_period;
      ssm_d   = single_shot;
      done_d  = 1'b0;
      np_d    = '0;
      if (lut_rsvd) err_d = 1'b1;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (!run_req) done_d = 1'b0;
        end
        ST_SETTLE: begin
          if (!run_req) begin
            state_d = ST_IDLE;
            done_d  = 1'b0;
          end else if (cnt_q == set_q - 1'b1) begin
            state_d = ST_RUN;
            cnt_d   = '0;
            np_d    = NP_W'(1);
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_RUN: begin
          if (!run_req) begin
            state_d = ST_IDLE;
            done_d  = 1'b0;
          end else if (cnt_q == per_q - 1'b1) begin
            cnt_d = '0;
            if (ssm_q) begin
              state_d = ST_IDLE;
              done_d  = 1'b1;
            end else if (np_q != '1) begin
              np_d = np_q + 1'b1;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      set_q   <= '0;
      per_q   <= '0;
      ssm_q   <= 1'b0;
      done_q  <= 1'b0;
      np_q    <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      set_q   <= set_d;
      per_q   <= per_d;
      ssm_q   <= ssm_d;
      done_q  <= done_d;
      np_q    <= np_d;
      err_q   <= err_d;
    end
  end

  always_comb begin
    conv_active  = (state_q != ST_IDLE);
    data_ready_n = ~((state_q == ST_RUN) &&
                     (ssm_q || (cnt_q < CNT_W'(PULSE_W))));
    settled_mark = (state_q == ST_RUN) && (np_q == NP_W'(FLAG_PULSE)) && !data_ready_n;
    rate_err     = err_q;
  end

  assert_halt_no_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !run_req |=> data_ready_n);
  assert_init_blocks_conv_R2: assert property (@(posedge clk) disable iff (!rst_n)
    init_busy |-> !conv_active);
  assert_start_ready_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_active) |-> data_ready_n);
  assert_mark_on_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    settled_mark |-> !data_ready_n);
  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_err && !soft_rst) |=> rate_err);
endmodule

// File: tb/conv_seq_test.sv
module conv_seq_test;
  logic clk = 1'b0;
  logic rst_n, rst_pin_n, start_pin, cmd_reset, cmd_start, cmd_stop, cfg_wr;
  logic [2:0] rate_code;
  logic low_power, single_shot;
  logic conv_active, data_ready_n, init_busy, settled_mark, rate_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  conv_seq uut (
    .clk(clk), .rst_n(rst_n), .rst_pin_n(rst_pin_n), .start_pin(start_pin),
    .cmd_reset(cmd_reset), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
    .cfg_wr(cfg_wr), .rate_code(rate_code), .low_power(low_power),
    .single_shot(single_shot), .conv_active(conv_active),
    .data_ready_n(data_ready_n), .init_busy(init_busy),
    .settled_mark(settled_mark), .rate_err(rate_err)
  );

  // {low_power, rate_code, settle S, period P}
  localparam logic [35:0] VEC [6] = '{
    {1'b0, 3'd0, 16'd296,  16'd74},
    {1'b0, 3'd1, 16'd584,  16'd146},
    {1'b0, 3'd2, 16'd1160, 16'd290},
    {1'b0, 3'd3, 16'd2312, 16'd578},
    {1'b1, 3'd0, 16'd584,  16'd146},
    {1'b1, 3'd1, 16'd1160, 16'd290}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_low(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (data_ready_n && n < 40000);
  endtask

  task automatic low_width(output int n);
    n = 0;
    while (!data_ready_n && n < 40000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic busy_len(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (init_busy && n < 100);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int n, w, lows;
    rst_n = 1'b0; rst_pin_n = 1'b1; start_pin = 1'b0; cmd_reset = 1'b0;
    cmd_start = 1'b0; cmd_stop = 1'b0; cfg_wr = 1'b0; rate_code = 3'd0;
    low_power = 1'b0; single_shot = 1'b0;
    step(3);
    // R1 reset state
    chk(data_ready_n && !conv_active && init_busy && !settled_mark && !rate_err,
        "R1", {data_ready_n, conv_active, init_busy, settled_mark, rate_err}, 5'b10100);
    rst_n = 1'b1;
    busy_len(n);
    chk(n == 18, "R2 init after chip reset", n, 18);

    // R3 halted: no data-ready
    lows = 0;
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (!data_ready_n) lows++;
    end
    chk(lows == 0, "R3 halted", lows, 0);

    // vector table: settle, width, period (R5 R6 R7 R12)
    for (int v = 0; v < 6; v++) begin
      low_power = VEC[v][35];
      rate_code = VEC[v][34:32];
      start_pin = 1'b1;
      @(negedge clk);
      chk(conv_active && data_ready_n, "R5 start keeps ready high", data_ready_n, 1);
      wait_low(n);
      chk(n + 1 == int'(VEC[v][31:16]) + 1, VEC[v][35] ? "R7 settle" : "R6 settle",
          n + 1, int'(VEC[v][31:16]) + 1);
      low_width(w);
      chk(w == 4, "R12 pulse width", w, 4);
      wait_low(n);
      chk(w + n == int'(VEC[v][15:0]), "R12 period", w + n, int'(VEC[v][15:0]));
      start_pin = 1'b0;
      step(2);
      chk(!conv_active && data_ready_n, "R3 pin low halts", conv_active, 0);
    end

    low_power = 1'b0; rate_code = 3'd0;
    // R3 start opcode with pin low, stop opcode
    cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    wait_low(n);
    chk(n == 297, "R3 start opcode", n, 297);
    cmd_stop = 1'b1;
    @(negedge clk);
    cmd_stop = 1'b0;
    @(negedge clk);
    chk(!conv_active && data_ready_n, "R3 stop opcode", conv_active, 0);
    lows = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (!data_ready_n) lows++;
    end
    chk(lows == 0, "R3 stays halted after stop", lows, 0);

    // R8 restart during settling
    start_pin = 1'b1;
    step(100);
    cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
    wait_low(n);
    chk(n == 296, "R8 restart in settling", n, 296);
    // R8 restart while running
    low_width(w);
    step(10);
    cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
    chk(conv_active && data_ready_n, "R8 back to settling", data_ready_n, 1);
    wait_low(n);
    chk(n == 296, "R8 restart in running", n, 296);
    start_pin = 1'b0;
    step(2);

    // R9 fourth pulse marker
    start_pin = 1'b1;
    for (int p = 1; p <= 6; p++) begin
      wait_low(n);
      chk(settled_mark == (p == 4), "R9 marker", settled_mark, (p == 4));
      low_width(w);
    end
    start_pin = 1'b0;
    step(2);

    // R11 / R4 single shot
    single_shot = 1'b1;
    start_pin = 1'b1;
    wait_low(n);
    chk(n == 297, "R11 single settle", n, 297);
    low_width(w);
    chk(w == 74, "R11 single width", w, 74);
    chk(!conv_active, "R11 halts after one", conv_active, 0);
    lows = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (!data_ready_n) lows++;
    end
    chk(lows == 0, "R11 no retrigger while held", lows, 0);
    start_pin = 1'b0;
    step(2);
    start_pin = 1'b1;
    wait_low(n);
    chk(n == 297, "R11 new start", n, 297);
    start_pin = 1'b0;
    single_shot = 1'b0;
    step(2);

    // R10 reserved code
    rate_code = 3'd7;
    start_pin = 1'b1;
    wait_low(n);
    chk(n == 18441, "R10 reserved timing", n, 18441);
    chk(rate_err, "R10 flag set", rate_err, 1);
    start_pin = 1'b0;
    rate_code = 3'd0;
    step(20);
    chk(rate_err, "R10 flag sticky", rate_err, 1);
    cmd_reset = 1'b1;
    @(negedge clk);
    cmd_reset = 1'b0;
    chk(!rate_err, "R10 cleared by reset", rate_err, 0);
    busy_len(n);
    chk(n == 18, "R2 init after reset opcode", n, 18);

    // R2 reset pin with start held through init
    start_pin = 1'b1;
    wait_low(n);
    rst_pin_n = 1'b0;
    step(3);
    chk(!conv_active && data_ready_n && init_busy, "R2 pin reset stops", conv_active, 0);
    rst_pin_n = 1'b1;
    busy_len(n);
    chk(n == 18, "R2 init after reset pin", n, 18);
    wait_low(n);
    chk(n == 297, "R2 no conversion during init", n, 297);
    start_pin = 1'b0;
    step(2);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule